// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

This block is a memory-mapped event timer. A single 64-bit counter advances by one on every clock while the timer is running. Several comparator channels watch it, and each one raises an event when the count reaches its programmed value. A channel can fire once, or it can reload itself by a programmed period after every match. Each event is delivered either as a wired interrupt, as a one-cycle pulse or as a latched level, on a line chosen by the channel, or as a message made of a data word and an address. Software reaches every register through a simple 32-bit read/write port.

A legacy routing switch overrides the line choice of channels 0 and 1 and sends them to two fixed lines, a system-tick line and a real-time-clock line. Periodic channels are programmed through a set-value sequence. After it is armed, one comparator write loads the first compare point and the next comparator write loads the period.

Top module: `event_timer`

## Requirements
- R1: The identity word at offset 0x000 holds the channel count minus one in bits [4:0] and the legacy-capable flag in bit 8. Read data appears on `rdata` one clock after the cycle in which `rd_en` is high.
- R2: The global control word at 0x010 has run in bit 0 and legacy routing in bit 1. Both are 0 after reset. The counter reads its low word at 0xF0 and its high word at 0xF4. It adds exactly one per clock while run is set, with the carry passing into the high word, and it holds its value while run is clear.
- R3: Writes to 0xF0 or 0xF4 load the counter only while run is clear. While the counter runs, such writes are ignored.
- R4: Each channel n has a control word at 0x100+32n, with these bits: 0 enable, 1 periodic, 2 set-value (always reads 0), 3 low-32-bit compare, 4 level mode, 5 message delivery, 6 message-capable (read-only), 7 periodic-capable (read-only), and [12:8] line number. The periodic bit and the message bit only take the value 1 on a channel whose capability allows it.
- R5: The comparator sits at +8 (low word) and +12 (high word). In one-shot mode a channel fires once, when the running counter equals the comparator, and the comparator keeps its value. With bit 3 set, only the low 32 bits are compared.
- R6: In periodic mode the comparator advances by the period after each match, so the channel fires once every period counts.
- R7: Writing the control word with periodic and set-value both 1 arms a sequence. The next comparator writes go to the compare value until a low-word write, and the writes after that go to the period until another low-word write. Reading the comparator afterwards returns the compare value, not the period.
- R8: An edge-mode match drives `irq_lines[line]` high for exactly one clock. The pulse appears on the clock edge at which the counter value equal to the comparator is consumed.
- R9: A level-mode match sets the channel's bit in the status word at 0x020, and the line stays high until software writes 1 to that bit.
- R10: While legacy routing is set (this needs legacy capability), channel 0 drives the tick line and channel 1 drives the RTC line, whatever their line fields and message bits say.
- R11: With message delivery on and no legacy override, a match produces a one-cycle `msg_valid` carrying the data word at +16 and the address at +20, and it drives no wired line. When several channels match in the same cycle, the lowest-numbered one is delivered.
- R12: A disabled channel produces no line activity and no message, and a latched status bit does not drive its line while the channel is disabled. The comparator and message registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_lines | output | NLINES | Wired interrupt lines |
| msg_valid | output | 1 | One-cycle message delivery strobe |
| msg_addr | output | 32 | Address of the delivered message |
| msg_data | output | 32 | Data of the delivered message |

## Verification
The bench goes after off-by-one timing first. It records, cycle by cycle, the exact clock on which each line or message strobe rises, so a design that compares against the already-incremented count fires one cycle early and fails the check. Periodic trains are checked with random start points and random periods. A design that loads the period as the compare value, or adds the period twice, produces the wrong cycle pattern. Further cases cover a 64-bit compare against a counter whose high word is nonzero (a design that ignores bit 3 fires or stays silent at the wrong time) and counter writes made while the counter runs (a design that accepts them reads back the written value). The remaining cases are legacy routing against a conflicting line number and message bit, two simultaneous message matches, and a latched status bit on a channel that is disabled afterwards.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  localparam int CFG_EN     = 0;
  localparam int CFG_PER    = 1;
  localparam int CFG_SETV   = 2;
  localparam int CFG_M32    = 3;
  localparam int CFG_LVL    = 4;
  localparam int CFG_MSG    = 5;
  localparam int CFG_MSGCAP = 6;
  localparam int CFG_PERCAP = 7;
  localparam int CFG_RT_LSB = 8;
  localparam int CFG_RT_W   = 5;

  localparam logic [11:0] A_ID   = 12'h000;
  localparam logic [11:0] A_GCFG = 12'h010;
  localparam logic [11:0] A_STAT = 12'h020;
  localparam logic [11:0] A_CNTL = 12'h0F0;
  localparam logic [11:0] A_CNTH = 12'h0F4;

  localparam logic [3:0] CH_PAGE = 4'h1;
  localparam logic [4:0] O_CFG  = 5'h00;
  localparam logic [4:0] O_CMPL = 5'h08;
  localparam logic [4:0] O_CMPH = 5'h0C;
  localparam logic [4:0] O_MDAT = 5'h10;
  localparam logic [4:0] O_MADR = 5'h14;

  typedef enum logic [1:0] {SV_IDLE, SV_CMP, SV_PER} sv_e;
endpackage

// File: rtl/evtmr_counter.sv
module evtmr_counter #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [31:0]   wdata,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (wr_lo && !run) cnt[31:0] <= wdata;
    else if (wr_hi && !run) cnt[CW-1:32] <= wdata[CW-33:0];
    else if (run) cnt <= cnt + 1'b1;
  end

  // R2: one step per clock while running
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    run |=> cnt == $past(cnt) + 1'b1);
  // R3: no change while stopped and not written
  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_lo && !wr_hi) |=> $stable(cnt));
endmodule

// File: rtl/evtmr_channel.sv
module evtmr_channel import evtmr_pkg::*; #(
  parameter bit PER_OK = 1'b1,
  parameter bit MSG_OK = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic [63:0]         cnt,
  input  logic                wr_cfg,
  input  logic                wr_cmp_lo,
  input  logic                wr_cmp_hi,
  input  logic                wr_mdat,
  input  logic                wr_madr,
  input  logic [31:0]         wdata,
  input  logic                stat_clr,
  output logic [31:0]         cfg_word,
  output logic [63:0]         cmp_val,
  output logic [31:0]         mdat,
  output logic [31:0]         madr,
  output logic                fire,
  output logic                en,
  output logic                lvl,
  output logic                msg,
  output logic                stat,
  output logic [CFG_RT_W-1:0] route
);
  logic        per, m32;
  logic [63:0] period;
  sv_e         stage;

  always_comb begin
    fire = run && en && (m32 ? (cnt[31:0] == cmp_val[31:0]) : (cnt == cmp_val));
    cfg_word = '0;
    cfg_word[CFG_EN]     = en;
    cfg_word[CFG_PER]    = per;
    cfg_word[CFG_M32]    = m32;
    cfg_word[CFG_LVL]    = lvl;
    cfg_word[CFG_MSG]    = msg;
    cfg_word[CFG_MSGCAP] = MSG_OK;
    cfg_word[CFG_PERCAP] = PER_OK;
    cfg_word[CFG_RT_LSB +: CFG_RT_W] = route;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; per <= 1'b0; m32 <= 1'b0; lvl <= 1'b0; msg <= 1'b0;
      route <= '0; cmp_val <= '0; period <= '0; mdat <= '0; madr <= '0;
      stage <= SV_IDLE; stat <= 1'b0;
    end else begin
      if (wr_cfg) begin
        en    <= wdata[CFG_EN];
        per   <= wdata[CFG_PER] & PER_OK;
        m32   <= wdata[CFG_M32];
        lvl   <= wdata[CFG_LVL];
        msg   <= wdata[CFG_MSG] & MSG_OK;
        route <= wdata[CFG_RT_LSB +: CFG_RT_W];
        if (wdata[CFG_SETV] && wdata[CFG_PER] && PER_OK) stage <= SV_CMP;
      end
      if (wr_cmp_lo) begin
        if (stage == SV_PER) begin
          period[31:0] <= wdata;
          stage <= SV_IDLE;
        end else begin
          cmp_val[31:0] <= wdata;
          if (stage == SV_CMP) stage <= SV_PER;
        end
      end else if (wr_cmp_hi) begin
        if (stage == SV_PER) period[63:32] <= wdata;
        else cmp_val[63:32] <= wdata;
      end else if (fire && per) begin
        cmp_val <= cmp_val + period;
      end
      if (wr_mdat) mdat <= wdata;
      if (wr_madr) madr <= wdata;
      if (fire && lvl) stat <= 1'b1;
      else if (stat_clr) stat <= 1'b0;
    end
  end

  // R5: one-shot match leaves the comparator alone
  p_oneshot_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && !per && !wr_cmp_lo && !wr_cmp_hi) |=> $stable(cmp_val));
  // R6: periodic match advances by the period
  p_period_add_r6: assert property (@(posedge clk) disable iff (rst)
    (fire && per && !wr_cmp_lo && !wr_cmp_hi) |=> cmp_val == $past(cmp_val) + $past(period));
  // R9: level match latches status
  p_status_set_r9: assert property (@(posedge clk) disable iff (rst)
    (fire && lvl) |=> stat);
endmodule

// File: rtl/evtmr_router.sv
module evtmr_router import evtmr_pkg::*; #(
  parameter int NCH       = 3,
  parameter int NLINES    = 24,
  parameter int TICK_LINE = 0,
  parameter int RTC_LINE  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          legacy,
  input  logic [NCH-1:0]                fire,
  input  logic [NCH-1:0]                en,
  input  logic [NCH-1:0]                lvl,
  input  logic [NCH-1:0]                msg,
  input  logic [NCH-1:0]                stat,
  input  logic [NCH-1:0][CFG_RT_W-1:0]  route,
  input  logic [NCH-1:0][31:0]          mdat,
  input  logic [NCH-1:0][31:0]          madr,
  output logic [NLINES-1:0]             irq_lines,
  output logic                          msg_valid,
  output logic [31:0]                   msg_addr,
  output logic [31:0]                   msg_data
);
  logic [NLINES-1:0]   lines_d;
  logic                mv_d, leg;
  logic [31:0]         ma_d, md_d;
  logic [CFG_RT_W-1:0] idx;

  always_comb begin
    lines_d = '0; mv_d = 1'b0; ma_d = '0; md_d = '0; leg = 1'b0; idx = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      leg = legacy && (c < 2);
      if (leg) idx = (c == 0) ? CFG_RT_W'(TICK_LINE) : CFG_RT_W'(RTC_LINE);
      else idx = route[c];
      if (msg[c] && !leg) begin
        if (fire[c]) begin
          mv_d = 1'b1; ma_d = madr[c]; md_d = mdat[c];
        end
      end else if ((fire[c] || (lvl[c] && stat[c] && en[c])) && (int'(idx) < NLINES)) begin
        lines_d[idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lines <= '0; msg_valid <= 1'b0; msg_addr <= '0; msg_data <= '0;
    end else begin
      irq_lines <= lines_d; msg_valid <= mv_d; msg_addr <= ma_d; msg_data <= md_d;
    end
  end

  // R10: legacy routing puts channel 0 on the tick line
  p_legacy_tick_r10: assert property (@(posedge clk) disable iff (rst)
    (legacy && fire[0]) |=> irq_lines[TICK_LINE]);
  // R11: a delivered message always carries a strobe of one cycle
  p_msg_single_r11: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !(|(fire & msg))) |=> !msg_valid);
endmodule

// File: rtl/event_timer.sv
module event_timer import evtmr_pkg::*; #(
  parameter int         NCH       = 3,
  parameter int         NLINES    = 24,
  parameter int         TICK_LINE = 0,
  parameter int         RTC_LINE  = 8,
  parameter logic [7:0] PER_CAP   = 8'h05,
  parameter logic [7:0] MSG_CAP   = 8'hFF,
  parameter bit         LEG_CAP   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [11:0]       addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NLINES-1:0] irq_lines,
  output logic              msg_valid,
  output logic [31:0]       msg_addr,
  output logic [31:0]       msg_data
);
  localparam int SEL_W = 3;

  logic                         genable, legacy;
  logic [63:0]                  cnt;
  logic                         in_ch;
  logic [SEL_W-1:0]             ch_sel;
  logic [4:0]                   ch_off;
  logic [NCH-1:0][31:0]         ch_cfg, ch_mdat, ch_madr;
  logic [NCH-1:0][63:0]         ch_cmp;
  logic [NCH-1:0]               ch_fire, ch_en, ch_lvl, ch_msg, ch_stat;
  logic [NCH-1:0][CFG_RT_W-1:0] ch_rt;
  logic [31:0]                  rd_d;

  assign in_ch  = (addr[11:8] == CH_PAGE);
  assign ch_sel = addr[7:5];
  assign ch_off = addr[4:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      genable <= 1'b0; legacy <= 1'b0; rdata <= '0;
    end else begin
      if (wr_en && addr == A_GCFG) begin
        genable <= wdata[0];
        legacy  <= wdata[1] & LEG_CAP;
      end
      if (rd_en) rdata <= rd_d;
    end
  end

  evtmr_counter #(.CW(64)) u_cnt (
    .clk(clk), .rst(rst), .run(genable),
    .wr_lo(wr_en && addr == A_CNTL), .wr_hi(wr_en && addr == A_CNTH),
    .wdata(wdata), .cnt(cnt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit_page;
    assign hit_page = wr_en && in_ch && (ch_sel == SEL_W'(g));
    evtmr_channel #(.PER_OK(PER_CAP[g]), .MSG_OK(MSG_CAP[g])) u_ch (
      .clk(clk), .rst(rst), .run(genable), .cnt(cnt),
      .wr_cfg(hit_page && ch_off == O_CFG),
      .wr_cmp_lo(hit_page && ch_off == O_CMPL),
      .wr_cmp_hi(hit_page && ch_off == O_CMPH),
      .wr_mdat(hit_page && ch_off == O_MDAT),
      .wr_madr(hit_page && ch_off == O_MADR),
      .wdata(wdata),
      .stat_clr(wr_en && addr == A_STAT && wdata[g]),
      .cfg_word(ch_cfg[g]), .cmp_val(ch_cmp[g]), .mdat(ch_mdat[g]), .madr(ch_madr[g]),
      .fire(ch_fire[g]), .en(ch_en[g]), .lvl(ch_lvl[g]), .msg(ch_msg[g]),
      .stat(ch_stat[g]), .route(ch_rt[g])
    );
  end

  always_comb begin
    rd_d = '0;
    case (addr)
      A_ID:    rd_d = 32'(NCH - 1) | (LEG_CAP ? 32'h100 : 32'h0);
      A_GCFG:  rd_d = {30'd0, legacy, genable};
      A_STAT:  rd_d = 32'(ch_stat);
      A_CNTL:  rd_d = cnt[31:0];
      A_CNTH:  rd_d = cnt[63:32];
      default: begin
        if (in_ch && int'(ch_sel) < NCH) begin
          case (ch_off)
            O_CFG:   rd_d = ch_cfg[ch_sel];
            O_CMPL:  rd_d = ch_cmp[ch_sel][31:0];
            O_CMPH:  rd_d = ch_cmp[ch_sel][63:32];
            O_MDAT:  rd_d = ch_mdat[ch_sel];
            O_MADR:  rd_d = ch_madr[ch_sel];
            default: rd_d = '0;
          endcase
        end
      end
    endcase
  end

  evtmr_router #(.NCH(NCH), .NLINES(NLINES), .TICK_LINE(TICK_LINE), .RTC_LINE(RTC_LINE)) u_rt (
    .clk(clk), .rst(rst), .legacy(legacy),
    .fire(ch_fire), .en(ch_en), .lvl(ch_lvl), .msg(ch_msg), .stat(ch_stat),
    .route(ch_rt), .mdat(ch_mdat), .madr(ch_madr),
    .irq_lines(irq_lines), .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  // R12: a disabled channel never fires
  p_disabled_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !genable |-> !(|ch_fire));
endmodule

// File: tb/event_timer_test.sv
module event_timer_test;
  localparam int CLK_NS = 10;
  localparam int NL = 24;
  localparam logic [11:0] ID = 12'h000, GCFG = 12'h010, STAT = 12'h020,
                          CNTL = 12'h0F0, CNTH = 12'h0F4;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NL-1:0] irq_lines;
  logic msg_valid;
  logic [31:0] msg_addr, msg_data;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  event_timer uut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_lines(irq_lines), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data));

  always #(CLK_NS / 2) clk = ~clk;

  function automatic logic [11:0] cha(int c, int off);
    return 12'(12'h100 + c * 32 + off);
  endfunction

  function automatic logic [63:0] per_mask(int d, int p, int w);
    logic [63:0] m = '0;
    for (int n = 1; n <= w; n++) if (n >= d + 1 && ((n - d - 1) % p) == 0) m[n] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] lvl_mask(int d, int w);
    logic [63:0] m = '0;
    for (int n = d + 1; n <= w; n++) m[n] = 1'b1;
    return m;
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; d = rdata;
  endtask

  task automatic setcnt(input logic [31:0] hi, input logic [31:0] lo);
    do_wr(CNTH, hi); do_wr(CNTL, lo);
  endtask

  task automatic quiesce();
    do_wr(GCFG, 0);
    for (int c = 0; c < 3; c++) do_wr(cha(c, 0), 0);
    do_wr(STAT, 32'h7);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic watch(input int la, input int lb, input int w,
                       output logic [63:0] ma, output logic [63:0] mb,
                       output logic [63:0] mm, output logic [63:0] mo,
                       output logic [31:0] cd, output logic [31:0] ca);
    logic [NL-1:0] others;
    ma = '0; mb = '0; mm = '0; mo = '0; cd = '0; ca = '0;
    for (int n = 1; n <= w; n++) begin
      @(negedge clk);
      if (irq_lines[la]) ma[n] = 1'b1;
      if (irq_lines[lb]) mb[n] = 1'b1;
      if (msg_valid) begin mm[n] = 1'b1; cd = msg_data; ca = msg_addr; end
      others = irq_lines & ~((NL'(1) << la) | (NL'(1) << lb));
      if (others != '0) mo[n] = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] ma, mb, mm, mo;
    logic [31:0] cd, ca;
    int d, p, s;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk(64'(irq_lines), 0, "R8 lines idle after reset");
    chk(64'(msg_valid), 0, "R11 no message after reset");
    do_rd(ID, r);   chk(r, 32'h102, "R1 identity word");
    do_rd(GCFG, r); chk(r, 0, "R2 control word after reset");
    repeat (5) @(negedge clk);
    do_rd(CNTL, r); chk(r, 0, "R2 counter holds while stopped");

    // R2 counting and carry
    setcnt(0, 100);
    do_wr(GCFG, 1); repeat (4) @(negedge clk); do_wr(GCFG, 0);
    do_rd(CNTL, r); chk(r, 105, "R2 counts one per clock");
    setcnt(0, 32'hFFFF_FFFF);
    do_wr(GCFG, 1); do_wr(GCFG, 0);
    do_rd(CNTL, r); chk(r, 0, "R2 low word wraps");
    do_rd(CNTH, r); chk(r, 1, "R2 carry into high word");

    // R3 writes ignored while running
    setcnt(0, 50);
    do_wr(GCFG, 1); do_wr(CNTL, 32'hDEAD); do_wr(GCFG, 0);
    do_rd(CNTL, r); chk(r, 52, "R3 running counter ignores write");

    // R4 control word fields
    do_wr(cha(1, 0), 32'h1FFF);
    do_rd(cha(1, 0), r); chk(r, 32'h1F79, "R4 ch1 no periodic capability");
    do_wr(cha(0, 0), 32'h7);
    do_rd(cha(0, 0), r); chk(r, 32'hC3, "R4 ch0 set-value reads zero");
    quiesce();

    // R5 / R8 one-shot edge on line 5
    setcnt(0, 1000);
    do_wr(cha(2, 8), 1007); do_wr(cha(2, 12), 0);
    do_wr(cha(2, 0), 32'h501);
    do_wr(GCFG, 1);
    watch(5, 0, 30, ma, mb, mm, mo, cd, ca);
    chk(ma, per_mask(7, 1000, 30), "R8 single pulse at match cycle");
    chk(mo, 0, "R8 no other line");
    do_wr(GCFG, 0);
    do_rd(cha(2, 8), r); chk(r, 1007, "R5 comparator kept after one-shot");

    // R5 64-bit vs low-32 compare
    setcnt(1, 2000); do_wr(cha(2, 8), 2004);
    do_wr(GCFG, 1);
    watch(5, 0, 20, ma, mb, mm, mo, cd, ca);
    chk(ma, 0, "R5 full compare sees high word");
    do_wr(GCFG, 0);
    setcnt(1, 2000); do_wr(cha(2, 0), 32'h509);
    do_wr(GCFG, 1);
    watch(5, 0, 20, ma, mb, mm, mo, cd, ca);
    chk(ma, per_mask(4, 1000, 20), "R5 low-32 compare fires");
    quiesce();

    // R6 / R7 periodic via set-value, random points
    for (int it = 0; it < 4; it++) begin
      d = 2 + int'($urandom % 15); p = 3 + int'($urandom % 10); s = int'($urandom % 1000);
      quiesce();
      setcnt(0, 32'(s));
      do_wr(cha(0, 0), 32'h207);
      do_wr(cha(0, 12), 0); do_wr(cha(0, 8), 32'(s + d));
      do_wr(cha(0, 12), 0); do_wr(cha(0, 8), 32'(p));
      do_rd(cha(0, 8), r); chk(r, 32'(s + d), "R7 compare value not period");
      do_wr(GCFG, 1);
      watch(2, 0, 60, ma, mb, mm, mo, cd, ca);
      chk(ma, per_mask(d, p, 60), "R6 periodic pulse train");
    end
    quiesce();

    // R9 level latch and W1C
    setcnt(0, 300); do_wr(cha(2, 8), 305); do_wr(cha(2, 12), 0);
    do_wr(cha(2, 0), 32'h511);
    do_wr(GCFG, 1);
    watch(5, 0, 20, ma, mb, mm, mo, cd, ca);
    chk(ma, lvl_mask(5, 20), "R9 level held after match");
    do_wr(GCFG, 0);
    do_rd(STAT, r); chk(r, 4, "R9 status bit set");
    do_wr(STAT, 4); @(negedge clk);
    chk(64'(irq_lines[5]), 0, "R9 line drops after clear");
    do_rd(STAT, r); chk(r, 0, "R9 status cleared");

    // R12 latched status masked by disable; disabled channel silent
    setcnt(0, 300); do_wr(GCFG, 1);
    repeat (10) @(negedge clk);
    do_wr(GCFG, 0);
    do_wr(cha(2, 0), 32'h510); @(negedge clk); @(negedge clk);
    chk(64'(irq_lines[5]), 0, "R12 disabled channel masks status");
    do_rd(STAT, r); chk(r, 4, "R12 status kept while disabled");
    quiesce();
    setcnt(0, 400); do_wr(cha(2, 8), 405); do_wr(cha(2, 16), 32'hABCD);
    do_wr(cha(2, 0), 32'h500);
    do_wr(GCFG, 1);
    watch(5, 0, 20, ma, mb, mm, mo, cd, ca);
    chk(ma | mo | mm, 0, "R12 disabled channel silent");
    do_wr(GCFG, 0);
    do_rd(cha(2, 8), r);  chk(r, 405, "R12 comparator retained");
    do_rd(cha(2, 16), r); chk(r, 32'hABCD, "R12 message data retained");

    // R11 message delivery
    quiesce();
    setcnt(0, 500); do_wr(cha(2, 8), 503);
    do_wr(cha(2, 16), 32'h1234_5678); do_wr(cha(2, 20), 32'hFEE0_0000);
    do_wr(cha(2, 0), 32'h521);
    do_wr(GCFG, 1);
    watch(5, 0, 15, ma, mb, mm, mo, cd, ca);
    chk(mm, per_mask(3, 1000, 15), "R11 message strobe timing");
    chk(ma | mo, 0, "R11 no wired line with message");
    chk({ca, cd}, {32'hFEE0_0000, 32'h1234_5678}, "R11 message address and data");
    quiesce();
    setcnt(0, 600);
    do_wr(cha(0, 8), 603); do_wr(cha(0, 12), 0); do_wr(cha(0, 16), 32'h11);
    do_wr(cha(2, 8), 603); do_wr(cha(2, 16), 32'h22);
    do_wr(cha(0, 0), 32'h21); do_wr(cha(2, 0), 32'h21);
    do_wr(GCFG, 1);
    watch(5, 0, 15, ma, mb, mm, mo, cd, ca);
    chk(mm, per_mask(3, 1000, 15), "R11 one strobe for simultaneous match");
    chk(cd, 32'h11, "R11 lowest channel wins");

    // R10 legacy routing
    quiesce();
    setcnt(0, 700);
    do_wr(cha(0, 8), 703); do_wr(cha(1, 8), 703); do_wr(cha(1, 12), 0);
    do_wr(cha(0, 0), 32'h301); do_wr(cha(1, 0), 32'h421);
    do_wr(GCFG, 3);
    watch(0, 8, 15, ma, mb, mm, mo, cd, ca);
    chk(ma, per_mask(3, 1000, 15), "R10 channel 0 on tick line");
    chk(mb, per_mask(3, 1000, 15), "R10 channel 1 on RTC line");
    chk(mm | mo, 0, "R10 route field and message bit overridden");
    quiesce();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule